// File: doc/BRIEF.md
# Telemetry Line Code Encoder

This block turns a serial NRZ-L bit stream into one of eight run-time selectable telemetry line codes. It runs on a system clock at twice the bit rate. A bit strobe marks the start of each bit and a half-bit strobe marks its middle, so codes with a transition in the middle of the bit can be produced. The output is one registered line level per half-bit.

An optional additive scrambler can act on each bit before line coding. It XORs the data with feedback taken from a shift register of selectable length. The register is loaded with the scrambled bit, so a matching descrambler locks onto the stream by itself. The feedback taps can be mirrored to give the reverse-order sequence.

Control is a small state machine with three states. `ST_IDLE` is entered while the enable is low and holds the line at 0. `ST_HALF1` is entered on a bit strobe, and the first half-symbol is driven in it. `ST_HALF2` is entered from `ST_HALF1` on a half-bit strobe, and the second half-symbol is driven in it. A bit strobe seen in either `ST_HALF1` or `ST_HALF2` starts a new bit and moves to `ST_HALF1`. Dropping the enable moves any state to `ST_IDLE`.

Top module: `lc_line_encoder`

## Requirements
- R1: While reset is asserted, or on the clock edge after `en` is low, `line_out` is 0.
- R2: `line_out` changes only on the edge that samples `bit_stb`, on the edge that samples `half_stb` right after a bit start, or on the edge that samples `en` low. In every other cycle it holds its level.
- R3: Code 0 is NRZ-L: both halves equal the coded bit. Code 3 is Biphase-L: the first half is the coded bit and the second half is its complement.
- R4: Code 1 is NRZ-M: the level inverts at the bit start when the bit is 1. Code 2 is NRZ-S: the level inverts at the bit start when the bit is 0. Both hold the level through the middle of the bit.
- R5: Code 4 is Biphase-M and code 5 is Biphase-S. Both invert the level at every bit start. Biphase-M inverts it again mid-bit for a 1, and Biphase-S does so for a 0.
- R6: Code 6 is DM-M: the level inverts mid-bit for a 1, and at the start of a 0 that follows a 0. Code 7 is DM-S: the level inverts mid-bit for a 0, and at the start of a 1 that follows a 1. The first bit after enable has no boundary inversion.
- R7: `code_sel` is sampled only with `bit_stb`. A change to it at mid-bit does not alter that bit's second half.
- R8: With `rand_en` at 1, the coded bit is s = d XOR h[N] XOR h[T], where h[k] is the k-th previous coded bit (h = 0 after enable). `len_sel` 0, 1, 2, 3, 4 give N = 9, 11, 15, 17, 23 with forward T = 5, 9, 14, 14, 18. Values 5 to 7 give N = 15.
- R9: With `rand_rev` at 1, the tap becomes T = N minus the forward tap. For N = 9, 11, 15, 17, 23 this is 4, 2, 1, 3, 5.
- R10: With `rand_en` at 0, the data bit is coded unchanged and the scrambler history does not advance.
- R11: Dropping `en` clears the line level, the previous-bit memory and the scrambler history. Coding restarts from a 0 level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at twice the bit rate |
| rst_n | input | 1 | Active-low reset |
| en | input | 1 | Encoder enable |
| bit_stb | input | 1 | Bit start strobe; samples `din` |
| half_stb | input | 1 | Mid-bit strobe |
| din | input | 1 | NRZ-L data bit |
| code_sel | input | 3 | Line code select (0 to 7, see R3 to R6) |
| rand_en | input | 1 | Scrambler enable |
| len_sel | input | 3 | Scrambler length select |
| rand_rev | input | 1 | Mirror the scrambler taps |
| line_out | output | 1 | Encoded line level |

## Verification
The hardest cases to reach are those where the scrambler history must line up exactly with an independent model for every length and tap direction. A single slip of one bit in that history corrupts every later output. The bench resets the history by dropping the enable before each run. It then drives a seeded pseudo-random stream under NRZ-L, so the line shows each scrambled bit directly, and checks both halves of each bit. For the bypass case, the scrambler is switched off in the middle of a stream and then switched back on. The bench checks that the sequence continues as if the bypassed bits had never been sent.

// File: rtl/lc_pkg.sv
package lc_pkg;

    localparam int SCR_IDX_W = 5;

    typedef enum logic [2:0] {
        CODE_NRZL = 3'd0,
        CODE_NRZM = 3'd1,
        CODE_NRZS = 3'd2,
        CODE_BIL  = 3'd3,
        CODE_BIM  = 3'd4,
        CODE_BIS  = 3'd5,
        CODE_DMM  = 3'd6,
        CODE_DMS  = 3'd7
    } code_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HALF1 = 2'd1,
        ST_HALF2 = 2'd2
    } enc_state_e;

    function automatic logic [SCR_IDX_W-1:0] scr_len(input logic [2:0] sel);
        unique case (sel)
            3'd0:    scr_len = 5'd9;
            3'd1:    scr_len = 5'd11;
            3'd3:    scr_len = 5'd17;
            3'd4:    scr_len = 5'd23;
            default: scr_len = 5'd15;
        endcase
    endfunction

    function automatic logic [SCR_IDX_W-1:0] scr_tap(input logic [2:0] sel, input logic rev);
        logic [SCR_IDX_W-1:0] fwd;
        unique case (sel)
            3'd0:    fwd = 5'd5;
            3'd1:    fwd = 5'd9;
            3'd3:    fwd = 5'd14;
            3'd4:    fwd = 5'd18;
            default: fwd = 5'd14;
        endcase
        scr_tap = rev ? (scr_len(sel) - fwd) : fwd;
    endfunction

endpackage

// File: rtl/lc_scrambler.sv
module lc_scrambler
    import lc_pkg::*;
#(
    parameter int MAXN = 23
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       step,
    input  logic       active,
    input  logic [2:0] len_sel,
    input  logic       rev,
    input  logic       din,
    output logic       dout
);

    logic [MAXN-1:0]      hist_q;
    logic [SCR_IDX_W-1:0] len_idx;
    logic [SCR_IDX_W-1:0] tap_idx;
    logic                 fb;

    always_comb begin
        len_idx = scr_len(len_sel) - 5'd1;
        tap_idx = scr_tap(len_sel, rev) - 5'd1;
        fb      = hist_q[len_idx] ^ hist_q[tap_idx];
        dout    = active ? (din ^ fb) : din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (clr) begin
            hist_q <= '0;
        end else if (step && active) begin
            hist_q <= {hist_q[MAXN-2:0], dout};
        end
    end

endmodule

// File: rtl/lc_symbol_map.sv
module lc_symbol_map
    import lc_pkg::*;
(
    input  code_e code,
    input  logic  bit_in,
    input  logic  level,
    input  logic  prev_q,
    output logic  half_a,
    output logic  half_b,
    output logic  next_q
);

    logic pol_bit;

    always_comb begin
        pol_bit = (code == CODE_BIS || code == CODE_DMS) ? ~bit_in : bit_in;
        next_q  = pol_bit;
        unique case (code)
            CODE_NRZL: begin
                half_a = bit_in;
                half_b = bit_in;
            end
            CODE_NRZM: begin
                half_a = level ^ bit_in;
                half_b = half_a;
            end
            CODE_NRZS: begin
                half_a = level ^ ~bit_in;
                half_b = half_a;
            end
            CODE_BIL: begin
                half_a = bit_in;
                half_b = ~bit_in;
            end
            CODE_BIM, CODE_BIS: begin
                half_a = ~level;
                half_b = half_a ^ pol_bit;
            end
            CODE_DMM, CODE_DMS: begin
                half_a = level ^ (~prev_q & ~pol_bit);
                half_b = half_a ^ pol_bit;
            end
            default: begin
                half_a = 1'b0;
                half_b = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/lc_line_encoder.sv
module lc_line_encoder
    import lc_pkg::*;
#(
    parameter int SCR_MAXN = 23
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       bit_stb,
    input  logic       half_stb,
    input  logic       din,
    input  logic [2:0] code_sel,
    input  logic       rand_en,
    input  logic [2:0] len_sel,
    input  logic       rand_rev,
    output logic       line_out
);

    enc_state_e state_q, state_d;
    logic       coded_bit;
    logic       half_a, half_b, next_q;
    logic       second_q;
    logic       prev_q;

    lc_scrambler #(.MAXN(SCR_MAXN)) u_scr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (~en),
        .step    (en & bit_stb),
        .active  (rand_en),
        .len_sel (len_sel),
        .rev     (rand_rev),
        .din     (din),
        .dout    (coded_bit)
    );

    lc_symbol_map u_map (
        .code    (code_e'(code_sel)),
        .bit_in  (coded_bit),
        .level   (line_out),
        .prev_q  (prev_q),
        .half_a  (half_a),
        .half_b  (half_b),
        .next_q  (next_q)
    );

    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (bit_stb) state_d = ST_HALF1;
                ST_HALF1: begin
                    if (bit_stb)       state_d = ST_HALF1;
                    else if (half_stb) state_d = ST_HALF2;
                end
                ST_HALF2: if (bit_stb) state_d = ST_HALF1;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_out <= 1'b0;
            second_q <= 1'b0;
            prev_q   <= 1'b1;
        end else if (!en) begin
            line_out <= 1'b0;
            second_q <= 1'b0;
            prev_q   <= 1'b1;
        end else if (bit_stb) begin
            line_out <= half_a;
            second_q <= half_b;
            prev_q   <= next_q;
        end else if (half_stb && state_q == ST_HALF1) begin
            line_out <= second_q;
        end
    end

endmodule

// File: rtl/lc_line_encoder_chk.sv
module lc_line_encoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       bit_stb,
    input logic       half_stb,
    input logic       din,
    input logic [2:0] code_sel,
    input logic       rand_en,
    input logic       line_out
);

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !line_out); // R1

    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !bit_stb && !half_stb) |=> $stable(line_out)); // R2

    AST_BIL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (en && bit_stb && !rand_en && code_sel == 3'd3) |=> (line_out == $past(din))); // R3

    AST_NRZM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (en && bit_stb && !rand_en && code_sel == 3'd1) |=> (line_out == ($past(line_out) ^ $past(din)))); // R4

    AST_BIPH_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (en && bit_stb && (code_sel == 3'd4 || code_sel == 3'd5)) |=> (line_out != $past(line_out))); // R5

endmodule

bind lc_line_encoder lc_line_encoder_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .bit_stb  (bit_stb),
    .half_stb (half_stb),
    .din      (din),
    .code_sel (code_sel),
    .rand_en  (rand_en),
    .line_out (line_out)
);

// File: tb/sim_lc_line_encoder.sv
module sim_lc_line_encoder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       bit_stb = 1'b0;
    logic       half_stb = 1'b0;
    logic       din = 1'b0;
    logic [2:0] code_sel = 3'd0;
    logic       rand_en = 1'b0;
    logic [2:0] len_sel = 3'd2;
    logic       rand_rev = 1'b0;
    logic       line_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // Bench reference state
    logic m_line;
    logic m_prev;
    logic m_have_prev;
    logic hist [0:23];

    always #10 clk = ~clk;

    lc_line_encoder u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .bit_stb  (bit_stb),
        .half_stb (half_stb),
        .din      (din),
        .code_sel (code_sel),
        .rand_en  (rand_en),
        .len_sel  (len_sel),
        .rand_rev (rand_rev),
        .line_out (line_out)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 150000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_clear();
        m_line = 1'b0;
        m_have_prev = 1'b0;
        m_prev = 1'b0;
        for (int k = 0; k < 24; k++) hist[k] = 1'b0;
    endtask

    function automatic int ref_len(input logic [2:0] s);
        case (s)
            3'd0: return 9;
            3'd1: return 11;
            3'd3: return 17;
            3'd4: return 23;
            default: return 15;
        endcase
    endfunction

    function automatic int ref_tap(input logic [2:0] s, input logic r);
        int f;
        case (s)
            3'd0: f = 5;
            3'd1: f = 9;
            3'd3: f = 14;
            3'd4: f = 18;
            default: f = 14;
        endcase
        return r ? ref_len(s) - f : f;
    endfunction

    task automatic drop_enable();
        @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check(line_out, 1'b0, "R11 line cleared");
        model_clear();
        en = 1'b1;
    endtask

    // One bit: bit strobe then half strobe, code may change for mid-bit
    task automatic send_bit(input logic b, input logic [2:0] mid_code, input string req);
        logic s, e1, e2;
        int n, t;
        s = b;
        if (rand_en) begin
            n = ref_len(len_sel);
            t = ref_tap(len_sel, rand_rev);
            s = b ^ hist[n] ^ hist[t];
            for (int k = 23; k > 1; k--) hist[k] = hist[k-1];
            hist[1] = s;
        end
        case (code_sel)
            3'd0: begin e1 = s; e2 = s; end
            3'd1: begin e1 = s ? ~m_line : m_line; e2 = e1; end
            3'd2: begin e1 = s ? m_line : ~m_line; e2 = e1; end
            3'd3: begin e1 = s; e2 = ~s; end
            3'd4: begin e1 = ~m_line; e2 = s ? ~e1 : e1; end
            3'd5: begin e1 = ~m_line; e2 = s ? e1 : ~e1; end
            3'd6: begin
                e1 = (m_have_prev && !m_prev && !s) ? ~m_line : m_line;
                e2 = s ? ~e1 : e1;
            end
            default: begin
                e1 = (m_have_prev && m_prev && s) ? ~m_line : m_line;
                e2 = s ? e1 : ~e1;
            end
        endcase
        m_line = e2;
        m_prev = s;
        m_have_prev = 1'b1;
        @(negedge clk);
        din = b;
        bit_stb = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0;
        check(line_out, e1, {req, " first half"});
        code_sel = mid_code;
        half_stb = 1'b1;
        @(negedge clk);
        half_stb = 1'b0;
        check(line_out, e2, {req, " second half"});
    endtask

    task automatic send_word(input logic [2:0] code, input logic [15:0] w, input string req);
        code_sel = code;
        for (int i = 15; i >= 0; i--) send_bit(w[i], code, req);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check(line_out, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        bit_stb = 1'b1;
        din = 1'b1;
        @(negedge clk);
        bit_stb = 1'b0;
        check(line_out, 1'b0, "R1 enable low");
        en = 1'b1;
        model_clear();
    endtask

    task automatic t_level_codes();
        send_word(3'd0, 16'hA5C3, "R3 NRZ-L");
        drop_enable();
        send_word(3'd3, 16'h3C96, "R3 Biphase-L");
        drop_enable();
        send_word(3'd1, 16'hB217, "R4 NRZ-M");
        drop_enable();
        send_word(3'd2, 16'h4E8D, "R4 NRZ-S");
    endtask

    task automatic t_biphase();
        drop_enable();
        send_word(3'd4, 16'hC3A1, "R5 Biphase-M");
        drop_enable();
        send_word(3'd5, 16'h1F70, "R5 Biphase-S");
    endtask

    task automatic t_delay_mod();
        drop_enable();
        send_word(3'd6, 16'h0CF3, "R6 DM-M");
        drop_enable();
        send_word(3'd7, 16'hF30C, "R6 DM-S");
    endtask

    task automatic t_quiet();
        logic held;
        send_bit(1'b1, 3'd3, "R2 setup");
        held = line_out;
        din = ~din;
        code_sel = 3'd2;
        repeat (4) begin
            @(negedge clk);
            check(line_out, held, "R2 hold without strobe");
        end
        half_stb = 1'b1;
        @(negedge clk);
        half_stb = 1'b0;
        check(line_out, held, "R2 stray half strobe");
    endtask

    task automatic t_code_switch();
        drop_enable();
        code_sel = 3'd3;
        send_bit(1'b1, 3'd0, "R7 switch at mid-bit");
        code_sel = 3'd3;
        send_bit(1'b0, 3'd4, "R7 switch at mid-bit");
        send_bit(1'b1, 3'd4, "R7 new code at bit start");
    endtask

    task automatic t_scramble();
        logic b;
        void'($urandom(7));
        for (int r = 0; r < 2; r++) begin
            for (int sel = 0; sel < 6; sel++) begin
                rand_rev = r[0];
                len_sel = sel[2:0];
                rand_en = 1'b1;
                drop_enable();
                code_sel = 3'd0;
                for (int i = 0; i < 48; i++) begin
                    b = ($urandom() % 3) == 0;
                    send_bit(b, 3'd0, r ? "R9 reverse taps" : "R8 forward taps");
                end
            end
        end
    endtask

    task automatic t_bypass();
        len_sel = 3'd0;
        rand_rev = 1'b0;
        rand_en = 1'b1;
        drop_enable();
        code_sel = 3'd0;
        for (int i = 0; i < 20; i++) send_bit(i[0] ^ i[2], 3'd0, "R10 before bypass");
        rand_en = 1'b0;
        for (int i = 0; i < 12; i++) send_bit(i[1], 3'd0, "R10 bypass passthrough");
        rand_en = 1'b1;
        for (int i = 0; i < 20; i++) send_bit(1'b0, 3'd0, "R10 history resumes");
        rand_en = 1'b0;
    endtask

    task automatic t_disable();
        drop_enable();
        code_sel = 3'd1;
        send_bit(1'b1, 3'd1, "R11 level up");
        drop_enable();
        send_bit(1'b0, 3'd1, "R11 restart from 0");
        send_bit(1'b1, 3'd1, "R11 restart toggle");
    endtask

    initial begin
        model_clear();
        t_reset();
        t_level_codes();
        t_biphase();
        t_delay_mod();
        t_quiet();
        t_code_switch();
        t_scramble();
        t_bypass();
        t_disable();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule